// File: doc/BRIEF.md
# Supply-Aware Write-Inhibit Sequencer

This controller produces two active-low write-inhibit outputs for a non-volatile memory that is split into a lower half and an upper half. It watches two supply-good flags, one for the core rail and one for the I/O rail, and a power-down warning. While either rail is below its good threshold, both halves stay protected. The rails may come up in either order. Once both are good, a fixed release timer runs. When it expires, each half is opened for writes unless software has marked that half read-only.

A power-down warning closes both halves and keeps them closed until the rails have gone away and a fresh power-up has finished. A rail that drops without warning closes both halves immediately.

A write strobe opens a guard window. During that window, a warning-driven or software-driven change of either output is postponed, so an in-flight write sees a steady inhibit level. A supply fault is the only event that overrides the window. The three asynchronous supply and warning inputs pass through two-flop synchronizers before use.

Top module: `wr_inhibit_seq`

## Requirements
- R1: While reset is held and on the first cycle after reset, both outputs `wr_inh_n` read 2'b00 (both halves inhibited).
- R2: While `core_ok` or `io_ok` is low, both outputs stay 0, whichever rail rises first.
- R3: Both rails are set high before clock edge 1, with no warning, no read-only bit and no write window. Outputs are still 0 after edge REL_CYC+3 and read 1 after edge REL_CYC+4. Outputs never rise unless the power sequence has completed.
- R4: If either rail flag drops while powered, both outputs read 0 after the third clock edge that follows. This holds even inside a write guard window.
- R5: Bit 0 of `ro_req` and of `wr_inh_n` belongs to the lower half (address MSB 0), and bit 1 belongs to the upper half. A set `ro_req` bit drives its output low after the next edge, outside a guard window. Clearing the bit reopens only that half, and only when powered.
- R6: A `wr_strobe` sampled high at edge 1 freezes both outputs through edge WIN_CYC. A postponed change appears after edge WIN_CYC+1.
- R7: A `pwr_warn` rising while powered drives both outputs to 0 after the fourth clock edge, outside a guard window.
- R8: After a warning, the outputs stay 0 even if the warning is withdrawn. They reopen only after the rails drop and a full power-up per R3 completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_ok | input | 1 | Core rail above 90 percent (asynchronous) |
| io_ok | input | 1 | I/O rail above 90 percent (asynchronous) |
| pwr_warn | input | 1 | Imminent power removal (asynchronous) |
| wr_strobe | input | 1 | Memory write strobe, one cycle, synchronous |
| ro_req | input | 2 | Per-half read-only request, bit 0 lower half |
| wr_inh_n | output | 2 | Active-low write inhibit, bit 0 lower half |

## Verification
A write strobe can land in the same cycle as a supply fault or as a power-down warning. The bench raises the strobe together with a rail drop and expects the fault to win on the third edge regardless of the window. It also raises the strobe together with the warning and expects the output to hold through edge WIN_CYC and fall one edge later. A scoreboard queue holds the expected output value for each cycle, and a monitor compares each entry when its cycle comes.

// File: rtl/wis_pkg.sv
package wis_pkg;
  typedef enum logic [1:0] {PS_OFF, PS_WAIT, PS_ON, PS_DOWN} pwr_state_t;
  localparam int NUM_HALVES = 2;
endpackage

// File: rtl/wis_sync2.sv
module wis_sync2 #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/wis_seq_fsm.sv
module wis_seq_fsm import wis_pkg::*; #(
  parameter int REL_CYC = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rails_ok,
  input  logic       warn,
  output pwr_state_t state
);
  localparam int CW = $clog2(REL_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(REL_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= PS_OFF;
      cnt   <= '0;
    end else begin
      case (state)
        PS_OFF: begin
          cnt <= '0;
          if (rails_ok && !warn) state <= PS_WAIT;
        end
        PS_WAIT: begin
          if (!rails_ok)        state <= PS_OFF;
          else if (warn)        state <= PS_DOWN;
          else if (cnt == LAST) state <= PS_ON;
          else                  cnt <= cnt + 1'b1;
        end
        PS_ON: begin
          if (!rails_ok)  state <= PS_OFF;
          else if (warn)  state <= PS_DOWN;
        end
        default: begin
          if (!rails_ok) state <= PS_OFF;
        end
      endcase
    end
  end

  // R8: a warned shutdown only ends when the rails go away
  p_down_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_DOWN && rails_ok) |=> (state == PS_DOWN));

  // R3: release timer never runs past its limit
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_WAIT) |-> (cnt < CW'(REL_CYC)));
endmodule

// File: rtl/wis_wr_guard.sv
module wis_wr_guard #(
  parameter int WIN_CYC = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic busy
);
  localparam int CW = $clog2(WIN_CYC + 1);

  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n)         left <= '0;
    else if (strobe)    left <= CW'(WIN_CYC - 1);
    else if (left != 0) left <= left - 1'b1;
  end

  assign busy = strobe | (left != '0);

  // R6: a strobe keeps the window open on the following edge
  p_window_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && WIN_CYC > 1) |=> busy);
endmodule

// File: rtl/wr_inhibit_seq.sv
module wr_inhibit_seq import wis_pkg::*; #(
  parameter int CLK_NS      = 10,
  parameter int REL_CYC     = 50,
  parameter int WIN_CYC     = 14,
  parameter int DEADLINE_NS = 1000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  core_ok,
  input  logic                  io_ok,
  input  logic                  pwr_warn,
  input  logic                  wr_strobe,
  input  logic [NUM_HALVES-1:0] ro_req,
  output logic [NUM_HALVES-1:0] wr_inh_n
);
  // synchronizer + fsm entry + release timer + output flop + a full window
  localparam int WORST_CYC = 2 + 1 + REL_CYC + 1 + WIN_CYC;

  if (WORST_CYC * CLK_NS > DEADLINE_NS) begin : g_deadline_bad
    $error("wr_inhibit_seq: release path exceeds deadline");
  end

  logic [2:0] raw_in, syn_in;
  logic       rails_ok, warn_s, busy;
  pwr_state_t state;

  assign raw_in   = {pwr_warn, io_ok, core_ok};
  assign rails_ok = syn_in[0] & syn_in[1];
  assign warn_s   = syn_in[2];

  wis_sync2 #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  wis_seq_fsm #(.REL_CYC(REL_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .rails_ok(rails_ok), .warn(warn_s), .state(state)
  );

  wis_wr_guard #(.WIN_CYC(WIN_CYC)) u_guard (
    .clk(clk), .rst_n(rst_n), .strobe(wr_strobe), .busy(busy)
  );

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (!rst_n)         wr_inh_n[h] <= 1'b0;
      else if (!rails_ok) wr_inh_n[h] <= 1'b0;
      else if (!busy)     wr_inh_n[h] <= (state == PS_ON) && !ro_req[h];
    end

    // R5: read-only request closes its half
    p_ro_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ro_req[h] && !busy) |=> !wr_inh_n[h]);

    // R3: an output only opens from the powered state
    p_open_powered_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_inh_n[h]) |-> $past(state == PS_ON));
  end

  // R4: lost rail closes both halves regardless of the window
  p_fault_inhibit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rails_ok |=> (wr_inh_n == '0));

  // R6: outputs frozen while the guard window is open
  p_hold_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rails_ok) |=> $stable(wr_inh_n));
endmodule

// File: tb/tb_wr_inhibit_seq.sv
module tb_wr_inhibit_seq;
  localparam int R = 50;
  localparam int W = 14;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       core_ok = 1'b0, io_ok = 1'b0, pwr_warn = 1'b0, wr_strobe = 1'b0;
  logic [1:0] ro_req = 2'b00;
  logic [1:0] wr_inh_n;

  wr_inhibit_seq #(.CLK_NS(10), .REL_CYC(R), .WIN_CYC(W), .DEADLINE_NS(1000)) dut (
    .clk(clk), .rst_n(rst_n), .core_ok(core_ok), .io_ok(io_ok),
    .pwr_warn(pwr_warn), .wr_strobe(wr_strobe), .ro_req(ro_req), .wr_inh_n(wr_inh_n)
  );

  always #5 clk = ~clk;

  int cyc = 0, nchk = 0, nfail = 0;
  bit done = 0;
  int         q_cyc[$];
  logic [1:0] q_val[$];
  string      q_tag[$];

  task automatic expect_in(int k, logic [1:0] v, string tag);
    q_cyc.push_back(cyc + k);
    q_val.push_back(v);
    q_tag.push_back(tag);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: sample 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    cyc++;
    while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
      nchk++;
      if (wr_inh_n !== q_val[0]) begin
        nfail++;
        $display("FAIL %s cycle %0d: wr_inh_n=%b expected %b", q_tag[0], cyc, wr_inh_n, q_val[0]);
      end
      void'(q_cyc.pop_front());
      void'(q_val.pop_front());
      void'(q_tag.pop_front());
    end
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    expect_in(1, 2'b00, "R1");
    step(3);
    // R2: core rail alone, then I/O rail completes the pair
    core_ok = 1'b1;
    expect_in(R + 6, 2'b00, "R2");
    step(R + 8);
    io_ok = 1'b1;
    expect_in(R + 3, 2'b00, "R3");
    expect_in(R + 4, 2'b11, "R3");
    step(R + 6);
    // R5: lower half read-only, then cleared
    ro_req = 2'b01;
    expect_in(1, 2'b10, "R5");
    step(3);
    ro_req = 2'b00;
    expect_in(1, 2'b11, "R5");
    step(3);
    // R6: read-only change during a write window is postponed
    wr_strobe = 1'b1;
    ro_req = 2'b10;
    expect_in(W, 2'b11, "R6");
    expect_in(W + 1, 2'b01, "R6");
    step(1);
    wr_strobe = 1'b0;
    step(W + 3);
    ro_req = 2'b00;
    expect_in(1, 2'b11, "R5");
    step(3);
    // R4: I/O rail drop
    io_ok = 1'b0;
    expect_in(2, 2'b11, "R4");
    expect_in(3, 2'b00, "R4");
    step(5);
    io_ok = 1'b1;
    expect_in(R + 3, 2'b00, "R3");
    expect_in(R + 4, 2'b11, "R3");
    step(R + 6);
    // R4: fault overrides an open write window
    wr_strobe = 1'b1;
    core_ok = 1'b0;
    expect_in(3, 2'b00, "R4");
    step(1);
    wr_strobe = 1'b0;
    step(W + 3);
    core_ok = 1'b1;
    expect_in(R + 4, 2'b11, "R3");
    step(R + 6);
    // R7: warning closes both halves
    pwr_warn = 1'b1;
    expect_in(3, 2'b11, "R7");
    expect_in(4, 2'b00, "R7");
    step(6);
    // R8: withdrawing the warning does not reopen
    pwr_warn = 1'b0;
    expect_in(20, 2'b00, "R8");
    step(22);
    core_ok = 1'b0;
    io_ok = 1'b0;
    step(5);
    core_ok = 1'b1;
    io_ok = 1'b1;
    expect_in(R + 4, 2'b11, "R8");
    step(R + 6);
    // R6: warning inside a write window is postponed
    wr_strobe = 1'b1;
    pwr_warn = 1'b1;
    expect_in(W, 2'b11, "R6");
    expect_in(W + 1, 2'b00, "R6");
    step(1);
    wr_strobe = 1'b0;
    step(W + 3);
    // R5: clearing read-only while shut down keeps halves closed
    ro_req = 2'b01;
    step(2);
    ro_req = 2'b00;
    expect_in(3, 2'b00, "R5");
    step(5);
    if (q_cyc.size() != 0) begin
      nfail++;
      $display("FAIL R1 scoreboard: %0d entries left, expected 0", q_cyc.size());
    end
    done = 1;
    report();
  end
endmodule